// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port that moves 8-bit frames against a serial clock it generates itself. A host register port loads a byte for transmission, collects the byte that came in, and clears three status flags: transmit-buffer-empty, receive-buffer-full and overrun. Three control bits enable the transmitter, the receiver and the receive interrupts. The serial clock idles high and toggles only while a frame is moving. Data leaves the block least significant bit first, changes on the falling serial clock edge, and is sampled on the rising edge.

With the transmitter enabled, a frame starts only when software has handed over a byte by clearing the empty flag. With only the receiver enabled, frames run back to back. When a frame ends while the previous byte is still unread, the block raises the overrun flag and keeps the old byte. From then on it halts every frame in both directions until software clears the flag.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status register (address 1) reads 8'h01: the empty flag (bit 0) is 1, the full flag (bit 1) is 0 and the overrun flag (bit 2) is 0. The serial clock and the serial data output are high, the empty interrupt is high, and both receive interrupts are low.
- R2: A frame has exactly 8 rising serial clock edges and carries the byte least significant bit first. The data output changes only while the clock is low and is stable at every rising edge. Each clock phase lasts HALF system cycles. While no frame runs, the clock and the data line are high.
- R3: With the transmit enable (control bit 0) set, no frame starts while the empty flag is 1. Clearing the flag after writing the transmit data register (address 2) starts a frame with that byte, and the empty flag returns to 1 when the byte is taken.
- R4: A status flag is cleared only by writing 0 to its bit after a status read that returned it as 1. Writing 0 without such a read leaves the flag set, and writing 1 never changes a flag.
- R5: When a frame completes with the receive enable (control bit 1) set and the full flag at 0, the received byte appears in the receive data register (address 3) and the full flag becomes 1.
- R6: When a frame completes while the full flag is still 1, the overrun flag becomes 1, and the receive data register keeps the earlier byte.
- R7: While the overrun flag is 1, no frame starts and the full flag is not set, even if it has been cleared. Frames resume once the overrun flag is cleared.
- R8: The receive-full interrupt equals interrupt enable (control bit 2) AND the full flag. The receive-error interrupt equals interrupt enable AND the overrun flag. The transmit-empty interrupt follows the empty flag.
- R9: A control write that clears the transmit or receive enable during a frame aborts the frame. One cycle later the clock and the data line are high, the partial byte is not delivered, and the next frame starts again from bit 0.
- R10: With only the receive enable set, frames run back to back with the data output held high, and each completed frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing on status reads) |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 transmit data, 3 receive data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_out | output | 1 | Serial transmit data |
| ser_in | input | 1 | Serial receive data |
| irq_rx_full | output | 1 | Receive-buffer-full interrupt |
| irq_rx_err | output | 1 | Receive-error (overrun) interrupt |
| irq_tx_empty | output | 1 | Transmit-buffer-empty interrupt |

## Verification
The embedded assertions watch, on every cycle, the behaviour that is local in time. They check that the clock and the data line rest high between frames and that a clock phase never changes early. They also check that an overrun blocks both the full flag and any new clock activity, that a write of 1 leaves a flag intact, and that an abort idles the line. Only the bench scenarios can show the end-to-end behaviour, because it spans whole frames and register sequences. This covers the byte order of a frame, the handoff through the empty flag, and the read-then-write rule for clearing flags. It also covers delivery of data in loopback and in receive-only mode, the retained byte after an overrun, the restart after a cleared overrun, and an abort in the middle of a frame.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;

    localparam int FRAME_BITS = 8;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_TXD  = 2'd2,
        REG_RXD  = 2'd3
    } reg_sel_e;

    // bit 0 = transmit enable, bit 1 = receive enable, bit 2 = interrupt enable
    typedef struct packed {
        logic irq_en;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    // bit 0 = empty, bit 1 = full, bit 2 = overrun
    typedef struct packed {
        logic ovr;
        logic full;
        logic empty;
    } stat_t;

    typedef struct packed {
        logic start;
        logic adv;
        logic rise;
        logic done;
    } tick_t;

    function automatic ctrl_t decode_ctrl(input logic [FRAME_BITS-1:0] w);
        return ctrl_t'(w[2:0]);
    endfunction

    function automatic logic [FRAME_BITS-1:0] widen3(input logic [2:0] v);
        logic [FRAME_BITS-1:0] r;
        r = '0;
        r[2:0] = v;
        return r;
    endfunction

endpackage

// File: rtl/ssp_clkgen.sv
`timescale 1ns/1ps
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int HALF = 4,
    parameter int BITS = FRAME_BITS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  logic  abort,
    output logic  sclk,
    output logic  active,
    output tick_t tick
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [HW-1:0] HALF_M1 = HW'(HALF - 1);
    localparam logic [BW-1:0] LAST    = BW'(BITS - 1);

    logic          active_q;
    logic          sclk_q;
    logic [HW-1:0] half_q;
    logic [BW-1:0] bit_q;
    logic          wrap;

    assign wrap = active_q && (half_q == HALF_M1);

    always_comb begin
        tick       = '0;
        tick.start = !active_q && go && !abort;
        tick.rise  = wrap && !sclk_q && !abort;
        tick.adv   = wrap && sclk_q && (bit_q != LAST) && !abort;
        tick.done  = wrap && sclk_q && (bit_q == LAST) && !abort;
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b1;
            half_q   <= '0;
            bit_q    <= '0;
        end else if (tick.start) begin
            active_q <= 1'b1;
            sclk_q   <= 1'b0;
            half_q   <= '0;
            bit_q    <= '0;
        end else if (active_q) begin
            if (wrap) begin
                half_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else if (bit_q != LAST) begin
                    sclk_q <= 1'b0;
                    bit_q  <= bit_q + 1'b1;
                end else begin
                    active_q <= 1'b0;
                end
            end else begin
                half_q <= half_q + 1'b1;
            end
        end
    end

    assign sclk   = sclk_q;
    assign active = active_q;

    // a clock phase never ends before HALF cycles have passed
    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (active_q && (half_q != HALF_M1) && !abort) |=> $stable(sclk_q));

endmodule

// File: rtl/ssp_shifter.sv
`timescale 1ns/1ps
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int BITS = FRAME_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            abort,
    input  logic            tx_en,
    input  tick_t           tick,
    input  logic [BITS-1:0] tx_byte,
    input  logic            sin,
    output logic            sout,
    output logic [BITS-1:0] rx_byte
);
    logic            line_q;
    logic [BITS-1:0] txsh_q;
    logic [BITS-1:0] rxsh_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            line_q <= 1'b1;
            txsh_q <= '1;
        end else if (tick.start) begin
            line_q <= tx_en ? tx_byte[0] : 1'b1;
            txsh_q <= tx_en ? {1'b1, tx_byte[BITS-1:1]} : '1;
        end else if (tick.adv) begin
            line_q <= txsh_q[0];
            txsh_q <= {1'b1, txsh_q[BITS-1:1]};
        end else if (tick.done) begin
            line_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxsh_q <= '0;
        end else if (tick.rise) begin
            rxsh_q <= {sin, rxsh_q[BITS-1:1]};
        end
    end

    assign sout    = line_q;
    assign rx_byte = rxsh_q;

    // the data line never moves on a rising-edge sample cycle
    assert_no_change_at_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (tick.rise && !abort) |=> $stable(line_q));

endmodule

// File: rtl/ssp_regs.sv
`timescale 1ns/1ps
module ssp_regs
    import ssp_pkg::*;
#(
    parameter int BITS = FRAME_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [1:0]      bus_addr,
    input  logic [BITS-1:0] bus_wdata,
    output logic [BITS-1:0] bus_rdata,
    input  logic            tx_load,
    input  logic            rx_done,
    input  logic [BITS-1:0] rx_byte,
    output ctrl_t           ctrl,
    output stat_t           stat,
    output logic [BITS-1:0] tx_byte
);
    ctrl_t           ctrl_q;
    stat_t           stat_q, stat_d;
    stat_t           arm_q, arm_d;
    logic [BITS-1:0] txd_q;
    logic [BITS-1:0] rxd_q;
    logic            wr_stat, rd_stat;

    assign wr_stat = bus_wr && (bus_addr == REG_STAT);
    assign rd_stat = bus_rd && (bus_addr == REG_STAT);

    always_comb begin
        stat_d = stat_q;
        arm_d  = arm_q;
        if (rd_stat) arm_d = stat_q;
        if (wr_stat) begin
            if (arm_q.empty && !bus_wdata[0]) stat_d.empty = 1'b0;
            if (arm_q.full  && !bus_wdata[1]) stat_d.full  = 1'b0;
            if (arm_q.ovr   && !bus_wdata[2]) stat_d.ovr   = 1'b0;
        end
        if (tx_load) stat_d.empty = 1'b1;
        if (rx_done) begin
            if (stat_q.full)      stat_d.ovr  = 1'b1;
            else if (!stat_q.ovr) stat_d.full = 1'b1;
        end
        arm_d = stat_t'(arm_d & stat_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '{ovr: 1'b0, full: 1'b0, empty: 1'b1};
            arm_q  <= '0;
            txd_q  <= '0;
            rxd_q  <= '0;
        end else begin
            stat_q <= stat_d;
            arm_q  <= arm_d;
            if (bus_wr && (bus_addr == REG_CTRL)) ctrl_q <= decode_ctrl(bus_wdata);
            if (bus_wr && (bus_addr == REG_TXD))  txd_q  <= bus_wdata;
            if (rx_done && !stat_q.full && !stat_q.ovr) rxd_q <= rx_byte;
        end
    end

    always_comb begin
        unique case (bus_addr)
            REG_CTRL: bus_rdata = widen3(ctrl_q);
            REG_STAT: bus_rdata = widen3(stat_q);
            REG_TXD:  bus_rdata = txd_q;
            default:  bus_rdata = rxd_q;
        endcase
    end

    assign ctrl    = ctrl_q;
    assign stat    = stat_q;
    assign tx_byte = txd_q;

    // writing 1 to a flag bit leaves that flag set
    assert_write_one_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && bus_wdata[2] && stat_q.ovr) |=> stat_q.ovr);

    // a pending overrun keeps the full flag from being set
    assert_ovr_blocks_full_R7: assert property (@(posedge clk) disable iff (rst)
        (stat_q.ovr && !stat_q.full && !wr_stat) |=> !stat_q.full);

    // the empty flag comes back once the shifter takes the byte
    assert_empty_reload_R3: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> stat_q.empty);

endmodule

// File: rtl/sync_serial_port.sv
`timescale 1ns/1ps
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int HALF = 4,
    parameter int BITS = FRAME_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [1:0]      bus_addr,
    input  logic [BITS-1:0] bus_wdata,
    output logic [BITS-1:0] bus_rdata,
    output logic            ser_clk,
    output logic            ser_out,
    input  logic            ser_in,
    output logic            irq_rx_full,
    output logic            irq_rx_err,
    output logic            irq_tx_empty
);
    ctrl_t           ctrl;
    stat_t           stat;
    tick_t           tick;
    logic [BITS-1:0] tx_byte;
    logic [BITS-1:0] rx_byte;
    logic            active;
    logic            go;
    logic            abort;
    logic            tx_load;
    logic            rx_done;

    // one control write updates both enables at once; any enable dropped aborts
    assign abort = bus_wr && (bus_addr == REG_CTRL) &&
                   ((ctrl.tx_en && !bus_wdata[0]) || (ctrl.rx_en && !bus_wdata[1]));

    assign go = (ctrl.tx_en || ctrl.rx_en) && !stat.ovr &&
                (ctrl.tx_en ? !stat.empty : 1'b1);

    assign tx_load = tick.start && ctrl.tx_en;
    assign rx_done = tick.done && ctrl.rx_en;

    ssp_regs #(.BITS(BITS)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_load   (tx_load),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .ctrl      (ctrl),
        .stat      (stat),
        .tx_byte   (tx_byte)
    );

    ssp_clkgen #(.HALF(HALF), .BITS(BITS)) clkgen_i (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .abort  (abort),
        .sclk   (ser_clk),
        .active (active),
        .tick   (tick)
    );

    ssp_shifter #(.BITS(BITS)) shifter_i (
        .clk     (clk),
        .rst     (rst),
        .abort   (abort),
        .tx_en   (ctrl.tx_en),
        .tick    (tick),
        .tx_byte (tx_byte),
        .sin     (ser_in),
        .sout    (ser_out),
        .rx_byte (rx_byte)
    );

    assign irq_rx_full  = ctrl.irq_en && stat.full;
    assign irq_rx_err   = ctrl.irq_en && stat.ovr;
    assign irq_tx_empty = stat.empty;

    // between frames the clock and the data line rest high
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        !active |-> (ser_clk && ser_out));

    // an overrun holds the clock still
    assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (stat.ovr && !active) |=> (ser_clk && !active));

    // an abort idles clock and line on the next cycle
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
        abort |=> (ser_clk && ser_out && !active));

endmodule

// File: tb/sync_serial_port_tb.sv
`timescale 1ns/1ps
module sync_serial_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ser_clk, ser_out, ser_in;
    logic       irq_rx_full, irq_rx_err, irq_tx_empty;

    logic       loopback = 1'b1;
    logic       ext_in = 1'b1;
    logic [7:0] ext_pat = 8'h00;
    int         fall_idx = 0;
    int         rise_cnt = 0;
    logic [7:0] cap = 8'h00;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign ser_in = loopback ? ser_out : ext_in;

    sync_serial_port dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ser_clk      (ser_clk),
        .ser_out      (ser_out),
        .ser_in       (ser_in),
        .irq_rx_full  (irq_rx_full),
        .irq_rx_err   (irq_rx_err),
        .irq_tx_empty (irq_tx_empty)
    );

    // capture the line at each rising serial clock edge
    always @(posedge ser_clk) begin
        if (rise_cnt < 8) cap[rise_cnt[2:0]] = ser_out;
        rise_cnt = rise_cnt + 1;
    end

    // external transmitter for receive-only tests: drive on falling edge
    always @(negedge ser_clk) begin
        ext_in   = ext_pat[fall_idx[2:0]];
        fall_idx = fall_idx + 1;
    end

    function automatic logic [7:0] stat_word(input bit empty, input bit full, input bit ovr);
        return {5'b0, ovr, full, empty};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cap_reset();
        rise_cnt = 0;
        cap = 8'h00;
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] t;
        cap_reset();
        wr(2'd2, b);
        rd(2'd1, t);
        wr(2'd1, 8'hFE);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags(input logic [7:0] mask);
        logic [7:0] t;
        rd(2'd1, t);
        wr(2'd1, ~mask);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] b;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EED1234);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(2'd1, v);
        check("R1", "status", v, stat_word(1, 0, 0));
        check("R1", "ser_clk", ser_clk, 1);
        check("R1", "ser_out", ser_out, 1);
        check("R1", "irq_tx_empty", irq_tx_empty, 1);
        check("R1", "irq_rx_full", irq_rx_full, 0);
        check("R1", "irq_rx_err", irq_rx_err, 0);

        // R3: enabled but empty flag still 1 -> no frame
        wr(2'd0, 8'h07);
        cap_reset();
        wr(2'd2, 8'h3C);
        wait_cyc(30);
        check("R3", "no clock while empty set", rise_cnt, 0);

        // loopback traffic, first byte directed, rest random
        for (int i = 0; i < 20; i++) begin
            b = (i == 0) ? 8'h81 : 8'($urandom());
            send(b);
            wait_cyc(80);
            check("R2", "byte on line", cap, b);
            check("R2", "rising edges", rise_cnt, 8);
            check("R3", "empty after load", irq_tx_empty, 1);
            check("R8", "rx full irq", irq_rx_full, 1);
            if (i == 0) begin
                // R4: write 0 without a prior read does nothing; write 1 does nothing
                wr(2'd1, 8'hFD);
                rd(2'd1, v);
                check("R4", "full kept without read", v, stat_word(1, 1, 0));
                wr(2'd1, 8'hFF);
                rd(2'd1, v);
                check("R4", "full kept on write 1", v, stat_word(1, 1, 0));
            end
            rd(2'd1, v);
            check("R5", "status after rx", v, stat_word(1, 1, 0));
            rd(2'd3, v);
            check("R5", "rx data", v, b);
            wr(2'd1, 8'hFD);
            rd(2'd1, v);
            check("R4", "full cleared after read", v, stat_word(1, 0, 0));
            check("R8", "rx full irq low", irq_rx_full, 0);
        end

        // R6: overrun keeps the first byte
        send(8'hA5);
        wait_cyc(80);
        send(8'h5A);
        wait_cyc(80);
        rd(2'd1, v);
        check("R6", "overrun status", v, stat_word(1, 1, 1));
        rd(2'd3, v);
        check("R6", "old byte kept", v, 8'hA5);
        check("R8", "rx err irq", irq_rx_err, 1);

        // R7: stalled while overrun pending
        send(8'hC3);
        wait_cyc(80);
        check("R7", "no clock during overrun", rise_cnt, 0);
        rd(2'd1, v);
        check("R7", "empty flag held at 0", v, stat_word(0, 1, 1));
        clear_flags(8'h06);
        wait_cyc(80);
        check("R7", "resumed byte", cap, 8'hC3);
        rd(2'd3, v);
        check("R7", "resumed rx data", v, 8'hC3);
        check("R8", "err irq cleared", irq_rx_err, 0);
        clear_flags(8'h02);

        // R8: interrupt enable off
        wr(2'd0, 8'h03);
        send(8'h66);
        wait_cyc(80);
        rd(2'd1, v);
        check("R8", "full set with irq off", v, stat_word(1, 1, 0));
        check("R8", "rx full irq masked", irq_rx_full, 0);
        clear_flags(8'h02);

        // R9: abort in mid frame
        send(8'h0F);
        wait_cyc(20);
        wr(2'd0, 8'h00);
        check("R9", "clock idle after abort", ser_clk, 1);
        check("R9", "line idle after abort", ser_out, 1);
        wait_cyc(80);
        rd(2'd1, v);
        check("R9", "partial frame dropped", v, stat_word(1, 0, 0));
        wr(2'd0, 8'h03);
        send(8'hE7);
        wait_cyc(80);
        check("R9", "restart from bit 0", cap, 8'hE7);
        check("R9", "restart edge count", rise_cnt, 8);
        rd(2'd3, v);
        check("R9", "restart rx data", v, 8'hE7);
        clear_flags(8'h02);
        wr(2'd0, 8'h00);

        // R10: receive-only from an external source
        loopback = 1'b0;
        ext_pat  = 8'h9B;
        @(negedge clk);
        fall_idx = 0;
        cap_reset();
        wr(2'd0, 8'h02);
        wait_cyc(100);
        check("R10", "line held high", cap, 8'hFF);
        rd(2'd1, v);
        check("R10", "full after rx-only frame", v, stat_word(1, 1, 0));
        rd(2'd3, v);
        check("R10", "rx-only data", v, 8'h9B);
        wait_cyc(60);
        rd(2'd1, v);
        check("R6", "overrun in rx-only", v, stat_word(1, 1, 1));
        rd(2'd3, v);
        check("R6", "rx-only old byte kept", v, 8'h9B);
        cap_reset();
        wait_cyc(40);
        check("R7", "rx-only stall", rise_cnt, 0);
        wr(2'd0, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule